// File: doc/BRIEF.md
# Counter Channel Byte Register Port

This block is the host-facing register front end for one 24-bit counter channel. The host sees two byte locations. The data location is at even offset 2n and the control/status location is at odd offset 2n+1. Here a single select input (`ctrl_sel_i`) picks between them. Wide values move one byte at a time through a three-position byte pointer, least significant byte first. Writes to the data location fill the preset register. Reads from the data location come from the output latch. Each data access advances the pointer, and the pointer wraps from the third byte back to the first.

A control write carries a 2-bit target field in bits 6:5. Target 00 decodes the byte as a set of commands that can be combined: reset the pointer, clear flags, and one transfer. The other targets load one of three 5-bit configuration registers that the counting core uses: mode, input/output and index. The counting core itself sits outside this block. The block only issues one-cycle command strobes to it. The counter value can only be changed by filling the preset and then issuing the preset-to-counter strobe. A read of the control location returns the core's error and direction flags.

Top module: `cnt_port`

## Requirements
- R1: After reset the byte pointer is 0, the preset and output latch are 0, all three configuration registers are 0 and every strobe output is low.
- R2: A control write with bits 6:5 = 01 loads bits 4:0 into `mode_cfg_o`, with 10 into `io_cfg_o`, and with 11 into `idx_cfg_o`; the other two registers keep their values. All three update at the write edge.
- R3: A data write stores `wdata_i` into preset byte k (k=0 is bits 7:0, k=2 is bits 23:16), where k is the pointer value. It then advances the pointer 0→1→2→0.
- R4: A data read returns output-latch byte k on `rdata_o` in the same cycle (k is the pointer value). The read then advances the pointer with the same wrap.
- R5: A command byte (bits 6:5 = 00) with bit 0 set returns the pointer to 0 at the write edge.
- R6: In a command byte, bits 2:1 = 2 raise `clr_flags_o` and bits 2:1 = 3 raise `clr_err_o`. Each strobe lasts the single cycle after the write edge. Values 0 and 1 raise neither.
- R7: In a command byte, bits 4:3 select one transfer. Value 1 pulses `ld_cnt_o`. Value 2 captures `count_i` into the output latch at the write edge and pulses `latch_o`. Value 3 pulses `ld_psc_o`, with the prescaler value on `preset_o[7:0]`. Each pulse lasts the cycle after the write edge.
- R8: While `ctrl_sel_i` is 1, `rdata_o` is a status byte: bit 5 = `up_flag_i` (1 = counting up), bit 4 = `err_flag_i`, all other bits 0. Status reads do not move the pointer.
- R9: A command byte that resets the pointer and requests a transfer performs both at the same edge. The three following data reads return bytes 0, 1 and 2 of the newly latched value.
- R10: Configuration writes raise no strobe, leave the preset and latch unchanged and do not move the pointer.
- R11: When `wr_en_i` and `rd_en_i` are both high on the data location, only the write takes effect, and the pointer advances once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host write strobe |
| rd_en_i | input | 1 | Host read strobe |
| ctrl_sel_i | input | 1 | 0 = data location, 1 = control/status location |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte |
| count_i | input | 24 | Current counter value from the core |
| err_flag_i | input | 1 | Noise error flag from the core |
| up_flag_i | input | 1 | Direction flag from the core, 1 = up |
| preset_o | output | 24 | Preset register |
| mode_cfg_o | output | 5 | Counter mode configuration |
| io_cfg_o | output | 5 | Input/output configuration |
| idx_cfg_o | output | 5 | Index configuration |
| ld_cnt_o | output | 1 | Strobe: copy preset into counter |
| latch_o | output | 1 | Strobe: counter copied to output latch |
| ld_psc_o | output | 1 | Strobe: copy preset low byte into prescaler |
| clr_flags_o | output | 1 | Strobe: clear borrow, carry, compare, sign and index flags |
| clr_err_o | output | 1 | Strobe: clear error flag |

## Verification
Two actions can land at the same edge: a pointer reset and a latch capture, both carried in one command byte. The bench provokes this with a command byte of 0x15 while the pointer sits in mid-value and `count_i` holds a known pattern. It then judges the result by reading three data bytes, which must come back in order from byte 0 of the fresh latch value. The same pairing also shows up in the random phase, where command bytes carry random bit combinations. Every read there is compared against a model that applies the pointer reset and the capture together.

// File: rtl/cnt_port_pkg.sv
package cnt_port_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        TGT_CMD  = 2'b00,
        TGT_MODE = 2'b01,
        TGT_IO   = 2'b10,
        TGT_IDX  = 2'b11
    } tgt_e;

    typedef struct packed {
        logic ptr_clr;
        logic clr_flags;
        logic clr_err;
        logic ld_cnt;
        logic cap_latch;
        logic ld_psc;
    } cmd_t;
endpackage

// File: rtl/cnt_cmd_dec.sv
module cnt_cmd_dec
    import cnt_port_pkg::*;
(
    input  logic       valid_i,
    input  logic [6:0] byte_i,
    output cmd_t       cmd_o,
    output logic [2:0] cfg_we_o
);
    localparam int TGT_LSB = 5;
    localparam int CLR_LSB = 1;
    localparam int XFR_LSB = 3;

    logic [1:0] clr_f;
    logic [1:0] xfr_f;
    tgt_e       tgt;

    assign clr_f = byte_i[CLR_LSB +: 2];
    assign xfr_f = byte_i[XFR_LSB +: 2];
    assign tgt   = tgt_e'(byte_i[TGT_LSB +: 2]);

    always_comb begin
        cmd_o    = '0;
        cfg_we_o = '0;
        if (valid_i) begin
            case (tgt)
                TGT_CMD: begin
                    cmd_o.ptr_clr   = byte_i[0];
                    cmd_o.clr_flags = (clr_f == 2'd2);
                    cmd_o.clr_err   = (clr_f == 2'd3);
                    cmd_o.ld_cnt    = (xfr_f == 2'd1);
                    cmd_o.cap_latch = (xfr_f == 2'd2);
                    cmd_o.ld_psc    = (xfr_f == 2'd3);
                end
                TGT_MODE: cfg_we_o[0] = 1'b1;
                TGT_IO:   cfg_we_o[1] = 1'b1;
                TGT_IDX:  cfg_we_o[2] = 1'b1;
                default:  cfg_we_o    = '0;
            endcase
        end
    end
endmodule

// File: rtl/cnt_byte_ptr.sv
module cnt_byte_ptr #(
    parameter int NBYTES = 3,
    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             step_i,
    output logic [PTR_W-1:0] ptr_o
);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NBYTES - 1);

    logic [PTR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else if (step_i) begin
            ptr_d = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr_o = ptr_q;
endmodule

// File: rtl/cnt_port.sv
module cnt_port
    import cnt_port_pkg::*;
#(
    parameter int NBYTES = 3,
    parameter int CFG_W  = 5,
    localparam int VAL_W = NBYTES * BYTE_W,
    localparam int PTR_W = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              ctrl_sel_i,
    input  logic [BYTE_W-1:0] wdata_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic [VAL_W-1:0]  count_i,
    input  logic              err_flag_i,
    input  logic              up_flag_i,
    output logic [VAL_W-1:0]  preset_o,
    output logic [CFG_W-1:0]  mode_cfg_o,
    output logic [CFG_W-1:0]  io_cfg_o,
    output logic [CFG_W-1:0]  idx_cfg_o,
    output logic              ld_cnt_o,
    output logic              latch_o,
    output logic              ld_psc_o,
    output logic              clr_flags_o,
    output logic              clr_err_o
);
    localparam int ERR_BIT = 4;
    localparam int UP_BIT  = 5;

    typedef struct packed {
        logic [VAL_W-1:0] preset;
        logic [VAL_W-1:0] latch;
        logic [CFG_W-1:0] mode;
        logic [CFG_W-1:0] io;
        logic [CFG_W-1:0] idx;
        logic             clr_flags;
        logic             clr_err;
        logic             ld_cnt;
        logic             cap;
        logic             ld_psc;
    } state_t;

    state_t st_d, st_q;

    logic             data_wr, data_rd, ctl_wr;
    logic [PTR_W-1:0] ptr;
    cmd_t             cmd;
    logic [2:0]       cfg_we;
    logic [BYTE_W-1:0] lane, status;

    assign data_wr = wr_en_i & ~ctrl_sel_i;
    assign data_rd = rd_en_i & ~ctrl_sel_i & ~wr_en_i;
    assign ctl_wr  = wr_en_i & ctrl_sel_i;

    cnt_cmd_dec u_dec (
        .valid_i  (ctl_wr),
        .byte_i   (wdata_i[6:0]),
        .cmd_o    (cmd),
        .cfg_we_o (cfg_we)
    );

    cnt_byte_ptr #(.NBYTES(NBYTES)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (cmd.ptr_clr),
        .step_i (data_wr | data_rd),
        .ptr_o  (ptr)
    );

    always_comb begin
        st_d           = st_q;
        st_d.clr_flags = cmd.clr_flags;
        st_d.clr_err   = cmd.clr_err;
        st_d.ld_cnt    = cmd.ld_cnt;
        st_d.cap       = cmd.cap_latch;
        st_d.ld_psc    = cmd.ld_psc;
        if (data_wr) begin
            for (int b = 0; b < NBYTES; b++) begin
                if (ptr == PTR_W'(b)) st_d.preset[b*BYTE_W +: BYTE_W] = wdata_i;
            end
        end
        if (cmd.cap_latch) st_d.latch = count_i;
        if (cfg_we[0]) st_d.mode = wdata_i[CFG_W-1:0];
        if (cfg_we[1]) st_d.io   = wdata_i[CFG_W-1:0];
        if (cfg_we[2]) st_d.idx  = wdata_i[CFG_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        lane = '0;
        for (int b = 0; b < NBYTES; b++) begin
            if (ptr == PTR_W'(b)) lane = st_q.latch[b*BYTE_W +: BYTE_W];
        end
        status          = '0;
        status[UP_BIT]  = up_flag_i;
        status[ERR_BIT] = err_flag_i;
    end

    assign rdata_o     = ctrl_sel_i ? status : lane;
    assign preset_o    = st_q.preset;
    assign mode_cfg_o  = st_q.mode;
    assign io_cfg_o    = st_q.io;
    assign idx_cfg_o   = st_q.idx;
    assign ld_cnt_o    = st_q.ld_cnt;
    assign latch_o     = st_q.cap;
    assign ld_psc_o    = st_q.ld_psc;
    assign clr_flags_o = st_q.clr_flags;
    assign clr_err_o   = st_q.clr_err;
endmodule

// File: rtl/cnt_port_chk.sv
module cnt_port_chk #(
    parameter int VAL_W = 24,
    parameter int CFG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en_i,
    input logic             ctrl_sel_i,
    input logic [7:0]       wdata_i,
    input logic [7:0]       rdata_o,
    input logic             err_flag_i,
    input logic             up_flag_i,
    input logic [VAL_W-1:0] preset_o,
    input logic [CFG_W-1:0] mode_cfg_o,
    input logic             ld_cnt_o,
    input logic             latch_o,
    input logic             ld_psc_o,
    input logic             clr_flags_o,
    input logic             clr_err_o
);
    assert_load_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_cnt_o |-> $past(wr_en_i && ctrl_sel_i && wdata_i[6:5] == 2'b00 && wdata_i[4:3] == 2'd1));

    assert_one_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ld_cnt_o, latch_o, ld_psc_o}));

    assert_err_clear_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clr_err_o |-> $past(wr_en_i && ctrl_sel_i && wdata_i[6:5] == 2'b00 && wdata_i[2:1] == 2'd3));

    assert_clear_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(clr_flags_o && clr_err_o));

    assert_preset_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(preset_o) |-> $past(wr_en_i && !ctrl_sel_i));

    assert_mode_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(mode_cfg_o) |-> $past(wr_en_i && ctrl_sel_i && wdata_i[6:5] == 2'b01));

    assert_status_byte_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_sel_i |-> (rdata_o == {2'b00, up_flag_i, err_flag_i, 4'b0000}));
endmodule

bind cnt_port cnt_port_chk #(.VAL_W(VAL_W), .CFG_W(CFG_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_i     (wr_en_i),
    .ctrl_sel_i  (ctrl_sel_i),
    .wdata_i     (wdata_i),
    .rdata_o     (rdata_o),
    .err_flag_i  (err_flag_i),
    .up_flag_i   (up_flag_i),
    .preset_o    (preset_o),
    .mode_cfg_o  (mode_cfg_o),
    .ld_cnt_o    (ld_cnt_o),
    .latch_o     (latch_o),
    .ld_psc_o    (ld_psc_o),
    .clr_flags_o (clr_flags_o),
    .clr_err_o   (clr_err_o)
);

// File: tb/sim_cnt_port.sv
`timescale 1ns/1ps
module sim_cnt_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr = 1'b0, rd = 1'b0, cs = 1'b0;
    logic [7:0]  wd = '0;
    logic [7:0]  rdata;
    logic [23:0] cnt = '0;
    logic        errf = 1'b0, upf = 1'b0;
    logic [23:0] preset;
    logic [4:0]  mode, io, idx;
    logic        ld_cnt, latch, ld_psc, clr_f, clr_e;

    int nchk = 0;
    int nerr = 0;
    bit done = 0;

    // bench model
    logic [23:0] m_preset = '0, m_latch = '0;
    logic [4:0]  m_mode = '0, m_io = '0, m_idx = '0;
    int          m_ptr = 0;
    logic [4:0]  m_stb = '0; // {clr_flags, clr_err, ld_cnt, latch, ld_psc}

    always #4 clk = ~clk;

    cnt_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr), .rd_en_i(rd), .ctrl_sel_i(cs),
        .wdata_i(wd), .rdata_o(rdata), .count_i(cnt), .err_flag_i(errf), .up_flag_i(upf),
        .preset_o(preset), .mode_cfg_o(mode), .io_cfg_o(io), .idx_cfg_o(idx),
        .ld_cnt_o(ld_cnt), .latch_o(latch), .ld_psc_o(ld_psc),
        .clr_flags_o(clr_f), .clr_err_o(clr_e)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [7:0] status_byte(input logic u, input logic e);
        return {2'b00, u, e, 4'b0000};
    endfunction

    function automatic logic [7:0] latch_byte(input logic [23:0] v, input int k);
        return v[k*8 +: 8];
    endfunction

    task automatic check_outputs(input string req_stb);
        check("R3 preset", {8'h0, preset}, {8'h0, m_preset});
        check("R2 mode", {27'h0, mode}, {27'h0, m_mode});
        check("R2 io", {27'h0, io}, {27'h0, m_io});
        check("R2 idx", {27'h0, idx}, {27'h0, m_idx});
        check(req_stb, {27'h0, clr_f, clr_e, ld_cnt, latch, ld_psc}, {27'h0, m_stb});
    endtask

    // one host operation with model update and checks
    task automatic op(input logic w, input logic r, input logic c, input logic [7:0] d);
        @(negedge clk);
        wr = w; rd = r; cs = c; wd = d;
        #1;
        if (r && !w) begin
            if (c) check("R8 status", {24'h0, rdata}, {24'h0, status_byte(upf, errf)});
            else   check("R4 read byte", {24'h0, rdata}, {24'h0, latch_byte(m_latch, m_ptr)});
        end
        @(posedge clk);
        #1;
        m_stb = '0;
        if (w && !c) begin
            m_preset[m_ptr*8 +: 8] = d;
            m_ptr = (m_ptr + 1) % 3;
        end else if (r && !c) begin
            m_ptr = (m_ptr + 1) % 3;
        end
        if (w && c) begin
            case (d[6:5])
                2'b00: begin
                    if (d[0]) m_ptr = 0;
                    m_stb[4] = (d[2:1] == 2'd2);
                    m_stb[3] = (d[2:1] == 2'd3);
                    m_stb[2] = (d[4:3] == 2'd1);
                    m_stb[1] = (d[4:3] == 2'd2);
                    m_stb[0] = (d[4:3] == 2'd3);
                    if (d[4:3] == 2'd2) m_latch = cnt;
                end
                2'b01: m_mode = d[4:0];
                2'b10: m_io   = d[4:0];
                default: m_idx = d[4:0];
            endcase
        end
        check_outputs((w && c && d[6:5] == 2'b00) ? "R6/R7 strobes" : "R10 strobes idle");
        @(negedge clk);
        wr = 0; rd = 0; cs = 0; wd = '0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            nchk++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1357));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 preset", {8'h0, preset}, 32'h0);
        check("R1 cfg", {17'h0, mode, io, idx}, 32'h0);
        check("R1 strobes", {27'h0, clr_f, clr_e, ld_cnt, latch, ld_psc}, 32'h0);
        check("R1 read byte", {24'h0, rdata}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        // R3: three writes, LSB first
        op(1, 0, 0, 8'h56); op(1, 0, 0, 8'h34); op(1, 0, 0, 8'h12);
        check("R3 assembled", {8'h0, preset}, 32'h00123456);
        op(1, 0, 0, 8'h99); // wraps to byte 0
        check("R3 wrap", {8'h0, preset}, 32'h00123499);

        // R9: pointer at 1; reset pointer and latch together
        cnt = 24'hABCDEF;
        op(1, 0, 1, 8'h15);
        check("R9 latch strobe", {31'h0, latch}, 32'h1);
        op(0, 1, 0, 8'h00); op(0, 1, 0, 8'h00); op(0, 1, 0, 8'h00);
        op(0, 1, 0, 8'h00); // R4 wrap back to byte 0 (checked inside op)

        // R5: pointer reset alone, then write goes to byte 0
        op(1, 0, 0, 8'h11);
        op(1, 0, 1, 8'h01);
        op(1, 0, 0, 8'h77);
        check("R5 byte0 after reset", {24'h0, preset[7:0]}, 32'h77);

        // R6 / R7 directed commands
        op(1, 0, 1, 8'h08); check("R7 ld_cnt", {31'h0, ld_cnt}, 32'h1);
        op(1, 0, 1, 8'h18); check("R7 ld_psc", {31'h0, ld_psc}, 32'h1);
        op(1, 0, 1, 8'h04); check("R6 clr_flags", {31'h0, clr_f}, 32'h1);
        op(1, 0, 1, 8'h06); check("R6 clr_err", {31'h0, clr_e}, 32'h1);
        op(1, 0, 1, 8'h0C); check("R6 R7 combined", {30'h0, clr_f, ld_cnt}, 32'h3);

        // R2 / R10 configuration writes
        op(1, 0, 1, 8'h2A); op(1, 0, 1, 8'h55); op(1, 0, 1, 8'h7F);
        check("R10 preset kept", {8'h0, preset}, {8'h0, m_preset});
        op(0, 1, 0, 8'h00); // pointer unaffected by config writes (R10)

        // R8 status reads with flag variants
        upf = 1; errf = 0; op(0, 1, 1, 8'h00);
        upf = 0; errf = 1; op(0, 1, 1, 8'h00);
        upf = 1; errf = 1; op(0, 1, 1, 8'h00);
        op(0, 1, 0, 8'h00); // R8 pointer not moved

        // R11 write and read together
        op(1, 1, 0, 8'hC3);
        op(0, 1, 0, 8'h00);
        check("R11 single advance", {8'h0, preset}, {8'h0, m_preset});

        // random phase
        for (int i = 0; i < 500; i++) begin
            int kind;
            kind = $urandom % 6;
            cnt  = 24'($urandom);
            upf  = 1'($urandom);
            errf = 1'($urandom);
            case (kind)
                0: op(1, 0, 0, 8'($urandom));
                1: op(0, 1, 0, 8'h00);
                2: op(1, 0, 1, {1'($urandom), 2'b00, 5'($urandom)});
                3: op(1, 0, 1, 8'($urandom));
                4: op(0, 1, 1, 8'h00);
                default: op(1, 1, 0, 8'($urandom));
            endcase
        end

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule